// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port of a small device. It decodes the serial test-mode input through the standard sixteen-state controller and holds a three-bit instruction. Between the serial data input and output it places the register that the active instruction selects: a single bypass bit, a 32-bit identification word, or a boundary register with one cell per input pin and two cells per output pin. The serial output is retimed on the falling test clock edge. It is enabled only while the controller is in one of the two shift states.

The block also sits between the core and the output pads. In normal operation the core's data and enables reach the pads unchanged. The external-test and clamp instructions replace them with the contents of the boundary register's update stage. The high-impedance instruction turns off every output enable. Test-Logic-Reset, reached either by the reset pin or by holding the mode input high, makes the identification instruction active again.

Top module: `scan_port`

## Requirements
- R1: The controller follows the standard sixteen-state diagram on rising TCK. After five rising edges with TMS high it is in Test-Logic-Reset from any state. TRST_N low forces Test-Logic-Reset at once, without a clock edge, and pins return to core control at the same moment.
- R2: Whenever the controller is in Test-Logic-Reset, the active instruction becomes IDCODE (code 001). The pads then carry core data and enables, and the data path is the identification register.
- R3: The identification word is {VERSION[3:0], PART_ID[15:0], MFR_CODE[10:0], 1'b1}, bit 31 down to bit 0. It is loaded when leaving Capture-DR and shifted out least significant bit first.
- R4: In Capture-IR the instruction shift register loads 3'b001, which is shifted out least significant bit first. A shifted-in code becomes active only on the edge that leaves Update-IR.
- R5: Opcodes are EXTEST 000, IDCODE 001, SAMPLE 010, CLAMP 011, HIGHZ 100 and BYPASS 111. Codes 101 and 110 act as BYPASS. The bypass bit captures 0 and delays TDI by one shift.
- R6: Under SAMPLE the boundary register captures {pad_oe, pad_out, pad_in}, from MSB to LSB, with the inputs in the low N_IN bits. The pads keep following core data and enables.
- R7: Under EXTEST the pads carry the update stage: output data from bits N_IN+N_OUT-1:N_IN and enables from the top N_OUT bits. Capture samples the driven pad values.
- R8: The boundary register's update stage changes only on the edge leaving Update-DR, and only when SAMPLE or EXTEST is active. The pads never change while data is being shifted.
- R9: Under CLAMP the pads hold the update-stage values whatever the core does, and the bypass bit is the data path.
- R10: Under HIGHZ every pad_oe bit is 0 and the bypass bit is the data path.
- R11: TDO changes on falling TCK. TDO_OE is 1 only in Shift-IR and Shift-DR. Data enters at the most significant end of the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| tdo_oe | output | 1 | Enable for the tdo driver |
| pad_in | input | N_IN | Values seen at the input pads |
| core_out | input | N_OUT | Output data from the core |
| core_oe | input | N_OUT | Output enables from the core |
| pad_out | output | N_OUT | Data driven toward the output pads |
| pad_oe | output | N_OUT | Enables driven toward the output pads |

## Verification
Under EXTEST, one rising edge does two things: it captures the boundary cells on leaving Capture-DR, and it samples the pad values that those same cells are driving. Under CLAMP, the core inputs change between shifts while a data scan runs through the bypass bit. The bench provokes both by mixing random opcodes, random core values and random scan data, then loading a fresh update stage on top of an earlier one. It judges each case against a model of the update stage held in the bench. The model gives the captured word, the word shifted out, and the pad values during and after each scan.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Controller states; encoding is private to this block.
  typedef enum logic [3:0] {
    ST_RESET    = 4'h0,
    ST_IDLE     = 4'h1,
    ST_SEL_DR   = 4'h2,
    ST_CAP_DR   = 4'h3,
    ST_SH_DR    = 4'h4,
    ST_EX1_DR   = 4'h5,
    ST_PAUSE_DR = 4'h6,
    ST_EX2_DR   = 4'h7,
    ST_UPD_DR   = 4'h8,
    ST_SEL_IR   = 4'h9,
    ST_CAP_IR   = 4'hA,
    ST_SH_IR    = 4'hB,
    ST_EX1_IR   = 4'hC,
    ST_PAUSE_IR = 4'hD,
    ST_EX2_IR   = 4'hE,
    ST_UPD_IR   = 4'hF
  } tap_st_e;

  localparam int unsigned IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 3'b011;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  typedef enum logic [1:0] {
    SEL_BYPASS = 2'd0,
    SEL_IDCODE = 2'd1,
    SEL_BSR    = 2'd2
  } dr_sel_e;

  typedef struct packed {
    dr_sel_e dr_sel;    // register between tdi and tdo in the DR column
    logic    pins_ext;  // pads driven from the boundary update stage
    logic    pins_off;  // all pad enables forced low
  } ir_dec_t;

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e state
);

  tap_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RESET:    st_d = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     st_d = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_DR:   st_d = tms ? ST_SEL_IR   : ST_CAP_DR;
      ST_CAP_DR:   st_d = tms ? ST_EX1_DR   : ST_SH_DR;
      ST_SH_DR:    st_d = tms ? ST_EX1_DR   : ST_SH_DR;
      ST_EX1_DR:   st_d = tms ? ST_UPD_DR   : ST_PAUSE_DR;
      ST_PAUSE_DR: st_d = tms ? ST_EX2_DR   : ST_PAUSE_DR;
      ST_EX2_DR:   st_d = tms ? ST_UPD_DR   : ST_SH_DR;
      ST_UPD_DR:   st_d = tms ? ST_SEL_DR   : ST_IDLE;
      ST_SEL_IR:   st_d = tms ? ST_RESET    : ST_CAP_IR;
      ST_CAP_IR:   st_d = tms ? ST_EX1_IR   : ST_SH_IR;
      ST_SH_IR:    st_d = tms ? ST_EX1_IR   : ST_SH_IR;
      ST_EX1_IR:   st_d = tms ? ST_UPD_IR   : ST_PAUSE_IR;
      ST_PAUSE_IR: st_d = tms ? ST_EX2_IR   : ST_PAUSE_IR;
      ST_EX2_IR:   st_d = tms ? ST_UPD_IR   : ST_SH_IR;
      ST_UPD_IR:   st_d = tms ? ST_SEL_DR   : ST_IDLE;
      default:     st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st_q <= ST_RESET;
    else         st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_st_e         state,
  input  logic            tdi,
  output logic            ir_sout,
  output logic [IR_W-1:0] ir_active,
  output ir_dec_t         dec
);

  localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] sr_q, sr_d;
  logic [IR_W-1:0] act_q, act_d;
  logic            act_en;

  // Shift stage: capture pattern, then serial shift toward bit 0.
  always_comb begin
    sr_d = sr_q;
    if (state == ST_CAP_IR)     sr_d = CAP_PAT;
    else if (state == ST_SH_IR) sr_d = {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sr_q <= CAP_PAT;
    else         sr_q <= sr_d;
  end

  // Active stage: identification code in reset, shifted code at update.
  always_comb begin
    act_en = 1'b0;
    act_d  = act_q;
    if (state == ST_RESET) begin
      act_en = 1'b1;
      act_d  = OP_IDCODE;
    end else if (state == ST_UPD_IR) begin
      act_en = 1'b1;
      act_d  = sr_q;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     act_q <= OP_IDCODE;
    else if (act_en) act_q <= act_d;
  end

  always_comb begin
    dec.dr_sel   = SEL_BYPASS;
    dec.pins_ext = 1'b0;
    dec.pins_off = 1'b0;
    case (act_q)
      OP_EXTEST: begin dec.dr_sel = SEL_BSR; dec.pins_ext = 1'b1; end
      OP_SAMPLE: dec.dr_sel = SEL_BSR;
      OP_IDCODE: dec.dr_sel = SEL_IDCODE;
      OP_CLAMP:  dec.pins_ext = 1'b1;
      OP_HIGHZ:  dec.pins_off = 1'b1;
      default:   dec.dr_sel = SEL_BYPASS;
    endcase
  end

  assign ir_sout   = sr_q[0];
  assign ir_active = act_q;

endmodule

// File: rtl/scan_bsr.sv
module scan_bsr
  import scan_pkg::*;
#(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_OUT = 4,
  localparam int unsigned BLEN = N_IN + 2 * N_OUT
)(
  input  logic             tck,
  input  logic             trst_n,
  input  tap_st_e          state,
  input  logic             tdi,
  input  logic             sel,
  input  logic             pins_ext,
  input  logic             pins_off,
  input  logic [N_IN-1:0]  pad_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe,
  output logic             bsr_sout,
  output logic [BLEN-1:0]  upd_state
);

  localparam int unsigned DAT_LO = N_IN;
  localparam int unsigned OE_LO  = N_IN + N_OUT;

  logic [BLEN-1:0] sr_q, sr_d;
  logic [BLEN-1:0] upd_q;
  logic            upd_en;

  // Shift stage: snapshot of all pads, then serial shift.
  always_comb begin
    sr_d = sr_q;
    if (sel && state == ST_CAP_DR)     sr_d = {pad_oe, pad_out, pad_in};
    else if (sel && state == ST_SH_DR) sr_d = {tdi, sr_q[BLEN-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  // Update stage: loads only when leaving Update-DR.
  assign upd_en = sel && (state == ST_UPD_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     upd_q <= '0;
    else if (upd_en) upd_q <= sr_q;
  end

  for (genvar p = 0; p < N_OUT; p++) begin : g_pin
    assign pad_out[p] = pins_ext ? upd_q[DAT_LO + p] : core_out[p];
    assign pad_oe[p]  = pins_ext ? upd_q[OE_LO + p]  : (core_oe[p] & ~pins_off);
  end

  assign bsr_sout  = sr_q[0];
  assign upd_state = upd_q;

endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_pkg::*;
#(
  parameter int unsigned N_IN     = 4,
  parameter int unsigned N_OUT    = 4,
  parameter logic [10:0] MFR_CODE = 11'b00010100001,
  parameter logic [15:0] PART_ID  = 16'h00A5,
  parameter logic [3:0]  VERSION  = 4'h1
)(
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  input  logic [N_IN-1:0]  pad_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pad_out,
  output logic [N_OUT-1:0] pad_oe
);

  localparam int unsigned BLEN = N_IN + 2 * N_OUT;
  localparam int unsigned ID_W = 32;
  localparam logic [ID_W-1:0] ID_WORD = {VERSION, PART_ID, MFR_CODE, 1'b1};

  tap_st_e         tap_state;
  logic [IR_W-1:0] ir_act;
  ir_dec_t         ir_dec;
  logic            ir_sout;
  logic            bsr_sout;
  logic [BLEN-1:0] bsr_upd_q;
  logic            byp_q, byp_d;
  logic [ID_W-1:0] id_q, id_d;
  logic            ser_out;
  logic            shifting;
  logic            tdo_q, tdo_oe_q;

  scan_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (tap_state)
  );

  scan_ir u_ir (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (tap_state),
    .tdi       (tdi),
    .ir_sout   (ir_sout),
    .ir_active (ir_act),
    .dec       (ir_dec)
  );

  scan_bsr #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bsr (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (tap_state),
    .tdi       (tdi),
    .sel       (ir_dec.dr_sel == SEL_BSR),
    .pins_ext  (ir_dec.pins_ext),
    .pins_off  (ir_dec.pins_off),
    .pad_in    (pad_in),
    .core_out  (core_out),
    .core_oe   (core_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .bsr_sout  (bsr_sout),
    .upd_state (bsr_upd_q)
  );

  // Bypass bit and identification register.
  always_comb begin
    byp_d = byp_q;
    id_d  = id_q;
    if (ir_dec.dr_sel == SEL_BYPASS) begin
      if (tap_state == ST_CAP_DR)     byp_d = 1'b0;
      else if (tap_state == ST_SH_DR) byp_d = tdi;
    end
    if (ir_dec.dr_sel == SEL_IDCODE) begin
      if (tap_state == ST_CAP_DR)     id_d = ID_WORD;
      else if (tap_state == ST_SH_DR) id_d = {tdi, id_q[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q <= 1'b0;
      id_q  <= '0;
    end else begin
      byp_q <= byp_d;
      id_q  <= id_d;
    end
  end

  // Serial output selection.
  always_comb begin
    shifting = (tap_state == ST_SH_IR) || (tap_state == ST_SH_DR);
    if (tap_state == ST_SH_IR) begin
      ser_out = ir_sout;
    end else begin
      case (ir_dec.dr_sel)
        SEL_IDCODE: ser_out = id_q[0];
        SEL_BSR:    ser_out = bsr_sout;
        default:    ser_out = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q    <= 1'b0;
      tdo_oe_q <= 1'b0;
    end else begin
      tdo_q    <= ser_out;
      tdo_oe_q <= shifting;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = tdo_oe_q;

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_pkg::*;
#(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned N_OUT = 4,
  localparam int unsigned BLEN = N_IN + 2 * N_OUT
)(
  input logic             tck,
  input logic             trst_n,
  input logic             tms,
  input tap_st_e          state,
  input logic [IR_W-1:0]  ir_active,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] core_oe,
  input logic [N_OUT-1:0] pad_out,
  input logic [N_OUT-1:0] pad_oe,
  input logic             tdo_oe,
  input logic [BLEN-1:0]  bsr_upd
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             hi_cnt <= 3'd0;
    else if (!tms)           hi_cnt <= 3'd0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
  end

  // R1
  five_high_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_cnt == 3'd5) |-> (state == ST_RESET));

  // R2
  reset_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET) |=> (ir_active == OP_IDCODE));

  // R6
  sample_transparent_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_active == OP_SAMPLE) |-> (pad_out == core_out && pad_oe == core_oe));

  // R8
  update_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_DR) |=> $stable(bsr_upd));

  // R9
  clamp_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_active == OP_CLAMP && $past(ir_active) == OP_CLAMP) |->
      ($stable(pad_out) && $stable(pad_oe)));

  // R10
  highz_off_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_active == OP_HIGHZ) |-> (pad_oe == '0));

  // R11
  tdo_enable_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == (state == ST_SH_DR || state == ST_SH_IR));

endmodule

bind scan_port scan_port_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_scan_port_chk (
  .tck       (tck),
  .trst_n    (trst_n),
  .tms       (tms),
  .state     (tap_state),
  .ir_active (ir_act),
  .core_out  (core_out),
  .core_oe   (core_oe),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .tdo_oe    (tdo_oe),
  .bsr_upd   (bsr_upd_q)
);

// File: tb/test_scan_port.sv
module test_scan_port;

  localparam int TCK_PERIOD = 20;
  localparam int N_IN  = 4;
  localparam int N_OUT = 4;
  localparam int BLEN  = N_IN + 2 * N_OUT;
  localparam logic [15:0] PART = 16'h00A5;
  localparam logic [3:0]  VER  = 4'h1;
  localparam logic [10:0] MFR  = 11'b00010100001;

  logic             tck;
  logic             trst_n, tms, tdi;
  logic             tdo, tdo_oe;
  logic [N_IN-1:0]  pad_in;
  logic [N_OUT-1:0] core_out, core_oe, pad_out, pad_oe;

  int n_run, n_fail;
  logic last_tdo, last_oe;
  logic [BLEN-1:0] upd_m;

  scan_port #(.N_IN(N_IN), .N_OUT(N_OUT), .PART_ID(PART), .VERSION(VER)) i_scan_port (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  initial tck = 1'b0;
  always #(TCK_PERIOD / 2) tck = ~tck;

  function automatic logic [31:0] exp_id();
    return {VER, PART, MFR, 1'b1};
  endfunction

  function automatic logic [2*N_OUT-1:0] exp_pins(logic [2:0] op, logic [BLEN-1:0] upd,
                                                  logic [N_OUT-1:0] co, logic [N_OUT-1:0] coe);
    if (op == 3'b000 || op == 3'b011) return {upd[N_IN+N_OUT +: N_OUT], upd[N_IN +: N_OUT]};
    if (op == 3'b100) return {{N_OUT{1'b0}}, co};
    return {coe, co};
  endfunction

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'b000:  return "R7 extest";
      3'b001:  return "R2 idcode";
      3'b010:  return "R6 sample";
      3'b011:  return "R9 clamp";
      3'b100:  return "R10 highz";
      default: return "R5 bypass";
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic t, input logic d);
    @(negedge tck);
    #1;
    last_tdo = tdo;
    last_oe  = tdo_oe;
    tms = t;
    tdi = d;
  endtask

  task automatic shift_ir(input logic [2:0] code, output logic [2:0] cap, output bit oe_ok);
    oe_ok = 1'b1;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      tick(i == 2, code[i]);
      cap[i] = last_tdo;
      oe_ok &= last_oe;
    end
    tick(1, 0); tick(0, 0); tick(0, 0);
    oe_ok &= !last_oe;
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                          output bit oe_ok, output bit st_ok);
    logic [2*N_OUT-1:0] first;
    dout  = '0;
    oe_ok = 1'b1;
    st_ok = 1'b1;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      dout[i] = last_tdo;
      oe_ok &= last_oe;
      if (i == 0) first = {pad_oe, pad_out};
      else if ({pad_oe, pad_out} !== first) st_ok = 1'b0;
    end
    tick(1, 0); tick(0, 0); tick(0, 0);
    oe_ok &= !last_oe;
  endtask

  initial begin
    #(TCK_PERIOD * 150000);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0]  cap;
    logic [63:0] dout;
    bit          oe_ok, st_ok;
    logic [BLEN-1:0] pre;
    void'($urandom(32'd4711));
    n_run = 0; n_fail = 0;
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0;
    core_out = 4'h6; core_oe = 4'hC; pad_in = 4'h9;
    upd_m = '0;
    #(TCK_PERIOD * 3);
    chk("R11 tdo_oe in reset", tdo_oe, 0);
    chk("R2 pins follow core in reset", {pad_oe, pad_out}, {core_oe, core_out});
    @(negedge tck); #1 trst_n = 1'b1;
    tick(0, 0); tick(0, 0);

    // R2/R3: identification word selected straight after reset
    shift_dr(32, 64'h0, dout, oe_ok, st_ok);
    chk("R3 idcode after reset", dout[31:0], exp_id());
    chk("R11 tdo_oe only in shift", oe_ok, 1);

    // R6: preload through SAMPLE, pads stay on core
    shift_ir(3'b010, cap, oe_ok);
    chk("R4 capture pattern", cap, 3'b001);
    chk("R11 tdo_oe in shift-ir", oe_ok, 1);
    pre = 12'hA5C;
    shift_dr(BLEN, {52'h0, pre}, dout, oe_ok, st_ok);
    chk("R6 sample capture", dout[BLEN-1:0], {core_oe, core_out, pad_in});
    chk("R6 sample pins", {pad_oe, pad_out}, {core_oe, core_out});
    upd_m = pre;

    // R7: EXTEST drives preloaded values
    shift_ir(3'b000, cap, oe_ok);
    chk("R7 extest pins", {pad_oe, pad_out}, {pre[11:8], pre[7:4]});

    // R9: CLAMP holds pads while core toggles and bypass scans
    shift_ir(3'b011, cap, oe_ok);
    core_out = ~core_out; core_oe = ~core_oe;
    shift_dr(8, 64'hB7, dout, oe_ok, st_ok);
    chk("R9 clamp bypass path", dout[7:0], 8'h6E);
    chk("R9 clamp pins hold", {pad_oe, pad_out}, {pre[11:8], pre[7:4]});

    // R10: HIGHZ turns all enables off
    shift_ir(3'b100, cap, oe_ok);
    chk("R10 highz enables", pad_oe, 0);

    // R1: five TMS-high cycles from inside Shift-DR
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0); tick(0, 0);
    chk("R1 five-high reset pins", {pad_oe, pad_out}, {core_oe, core_out});
    shift_dr(32, 64'h0, dout, oe_ok, st_ok);
    chk("R1 five-high reset idcode", dout[31:0], exp_id());

    // R1: asynchronous TRST_N while EXTEST drives the pads
    shift_ir(3'b000, cap, oe_ok);
    chk("R7 extest pins again", {pad_oe, pad_out}, {pre[11:8], pre[7:4]});
    #3 trst_n = 1'b0;
    #1 chk("R1 async trst pins", {pad_oe, pad_out}, {core_oe, core_out});
    @(negedge tck); #1 trst_n = 1'b1;
    upd_m = '0;
    tick(0, 0); tick(0, 0);

    // Random mix of opcodes, core values and scan data
    for (int it = 0; it < 40; it++) begin
      logic [2:0]  op;
      logic [63:0] din, mask, exp;
      int          n;
      op = 3'($urandom % 8);
      shift_ir(op, cap, oe_ok);
      chk("R4 capture pattern", cap, 3'b001);
      chk("R11 tdo_oe in shift-ir", oe_ok, 1);
      core_out = 4'($urandom); core_oe = 4'($urandom); pad_in = 4'($urandom);
      #1 chk(req_of(op), {pad_oe, pad_out}, exp_pins(op, upd_m, core_out, core_oe));
      din = {$urandom, $urandom};
      if (op == 3'b000 || op == 3'b010) n = BLEN;
      else if (op == 3'b001) n = 32;
      else n = 8;
      mask = (64'd1 << n) - 64'd1;
      if (n == BLEN)    exp = {52'h0, exp_pins(op, upd_m, core_out, core_oe), pad_in};
      else if (n == 32) exp = {32'h0, exp_id()};
      else              exp = {din[62:0], 1'b0} & mask;
      shift_dr(n, din, dout, oe_ok, st_ok);
      chk(req_of(op), dout & mask, exp);
      chk("R11 tdo_oe in shift-dr", oe_ok, 1);
      chk("R8 pins stable while shifting", st_ok, 1);
      if (n == BLEN) upd_m = din[BLEN-1:0];
      chk("R8 pins after update", {pad_oe, pad_out}, exp_pins(op, upd_m, core_out, core_oe));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule